// File: doc/BRIEF.md
# Split-Phase Priority Arbiter

This block decides which of several requesters drives a shared IP interface whose transactions have separate address and data phases. There are `NUM_CHANNELS` channel requesters plus one bus-slave requester. Each requester raises a request line and supplies an address, a read/write flag, a burst flag, a beat count and write data. The arbiter picks the owner of the address phase by fixed priority. It steers the address-phase signals from that owner onto the IP side and returns address acknowledges to that owner alone. A grant is never taken back before its last address beat. When another request is waiting, the next owner is chosen during that last beat, so the next address phase starts on the very next cycle.

Each address phase that completes is pushed into a small in-order queue. The head of the queue owns the data phase. Write data is taken from that owner, and data acknowledges and read data go to that owner alone. The head is removed when the last data acknowledge of its transaction arrives. The data phase can therefore lag the address phase by up to `Q_DEPTH` transactions. When the queue is full, no new address phase is granted.

The address side is a state machine with three states. `ST_IDLE` means no address phase is active and nothing is waiting. `ST_ADDR` means an address phase is in progress. `ST_STALL` means a request is waiting but the queue is full. It has these transitions:
- IDLE→ADDR: a request is present and the queue has room.
- IDLE→STALL: a request is present and the queue is full.
- STALL→ADDR: the queue has room again.
- STALL→IDLE: the request went away.
- ADDR→ADDR (overlap): on the last beat, another request is waiting and the queue keeps room after the push.
- ADDR→STALL: on the last beat, another request is waiting but the queue would be full after the push.
- ADDR→IDLE: on the last beat, nothing else is waiting.

Top module: `split_phase_arbiter`

## Requirements
- R1: After synchronous reset (`rst` high) the arbiter is in `ST_IDLE`: `ip_addr_valid` is low, every acknowledge output is low, and the data-phase queue is empty.
- R2: The requester with the lowest index among those requesting wins. Channels occupy indices 0 to NUM_CHANNELS-1, and the bus-slave port is index NUM_CHANNELS, the lowest priority. When `BUS_FIRST` is 1, the bus-slave port instead outranks every channel.
- R3: From `ST_IDLE`, a request seen in cycle k gives `ip_addr_valid` high, for the winner, from cycle k+1.
- R4: The beat-count field of each requester holds the number of beats minus one (0 to 15 means 1 to 16 beats). An address phase ends after that many plus one address acknowledges.
- R5: Once an address phase is granted, its owner does not change until its last address acknowledge, even if a higher-priority request arrives.
- R6: When another requester is waiting at the last address beat and the queue keeps room after the push, the next address phase begins in the following cycle, with no cycle in which `ip_addr_valid` is low.
- R7: `ip_addr`, `ip_rnw`, `ip_burst` and `ip_beats` come from the address-phase owner. `ip_addr_ack` reaches only that owner's `req_addr_ack` bit; all other bits stay low.
- R8: Data phases are served in the order their address phases completed. Each data phase ends after its beat count plus one data acknowledges.
- R9: `ip_wdata` comes from the data-phase owner. `ip_data_ack` and `ip_rdata` reach only that owner's `req_data_ack` bit and `req_rdata` slice; the other bits and slices stay zero.
- R10: While the data-phase queue holds `Q_DEPTH` entries, no new address phase is granted, and `ip_addr_valid` stays low.
- R11: `ip_addr_ack` has no effect while no address phase is active, and `ip_data_ack` has no effect while the queue is empty. In both cases no acknowledge output rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_CHANNELS+1 | Request line per requester; held until its last address acknowledge |
| req_rnw | input | NUM_CHANNELS+1 | Read (1) / write (0) per requester |
| req_burst | input | NUM_CHANNELS+1 | Burst flag per requester |
| req_beats | input | (NUM_CHANNELS+1)*BEAT_W | Beat count minus one per requester |
| req_addr | input | (NUM_CHANNELS+1)*ADDR_W | Address per requester |
| req_wdata | input | (NUM_CHANNELS+1)*DATA_W | Write data per requester |
| req_addr_ack | output | NUM_CHANNELS+1 | Address acknowledge per requester |
| req_data_ack | output | NUM_CHANNELS+1 | Data acknowledge per requester |
| req_rdata | output | (NUM_CHANNELS+1)*DATA_W | Read data per requester |
| ip_addr_valid | output | 1 | An address phase is active |
| ip_rnw | output | 1 | Read/write flag of the address owner |
| ip_burst | output | 1 | Burst flag of the address owner |
| ip_beats | output | BEAT_W | Beat count minus one of the address owner |
| ip_addr | output | ADDR_W | Address of the address owner |
| ip_addr_ack | input | 1 | Address acknowledge from the IP |
| ip_wdata | output | DATA_W | Write data of the data-phase owner |
| ip_data_ack | input | 1 | Data acknowledge from the IP |
| ip_rdata | input | DATA_W | Read data from the IP |

## Verification
The bench builds the arbiter with three channels plus the bus port, 8-bit addresses, 16-bit data and a queue depth of 2. The shallow queue lets two one-beat transactions with data acknowledges held off drive the queue full, so the `ST_STALL` path and its release are reached within a few cycles. Four requesters are enough to show the ordering of channels 0 to 2 ahead of the bus port, a late high-priority request arriving during a long burst, and 16-beat phases at the top of the beat field.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Address-side states of the arbiter.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_STALL = 2'd2
    } addr_state_e;

endpackage

// File: rtl/arb_prio_pick.sv
// Fixed-priority picker: lowest index wins, or the top index (bus port)
// first when BUS_FIRST is set.
module arb_prio_pick #(
    parameter int NUM_REQ   = 5,
    parameter bit BUS_FIRST = 1'b0,
    localparam int IDX_W    = $clog2(NUM_REQ)
) (
    input  logic [NUM_REQ-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    assign any = |req;

    generate
        if (BUS_FIRST) begin : g_bus_first
            always_comb begin
                idx = '0;
                for (int i = NUM_REQ - 2; i >= 0; i--) begin
                    if (req[i]) idx = IDX_W'(i);
                end
                if (req[NUM_REQ-1]) idx = IDX_W'(NUM_REQ - 1);
            end
        end else begin : g_chan_first
            always_comb begin
                idx = '0;
                for (int i = NUM_REQ - 1; i >= 0; i--) begin
                    if (req[i]) idx = IDX_W'(i);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/arb_addr_fsm.sv
// Address-phase state machine: grant, beat counting, overlap of the next
// decision with the last beat, and hold-off while the data queue is full.
module arb_addr_fsm
    import arb_pkg::*;
#(
    parameter int NUM_REQ   = 5,
    parameter int BEAT_W    = 4,
    parameter int Q_DEPTH   = 4,
    parameter bit BUS_FIRST = 1'b0,
    localparam int IDX_W    = $clog2(NUM_REQ),
    localparam int CNT_W    = $clog2(Q_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ*BEAT_W-1:0] req_beats,
    input  logic                      ip_addr_ack,
    input  logic [CNT_W-1:0]          q_count,
    input  logic                      q_pop,
    output logic                      addr_active,
    output logic [IDX_W-1:0]          addr_owner,
    output logic [BEAT_W-1:0]         addr_beats,
    output logic                      push
);

    addr_state_e        state_q, state_d;
    logic [IDX_W-1:0]   owner_q, owner_d;
    logic [BEAT_W-1:0]  beats_q, beats_d;
    logic [BEAT_W-1:0]  cnt_q, cnt_d;

    logic [NUM_REQ-1:0] masked;
    logic               win_any;
    logic [IDX_W-1:0]   win_idx;
    logic [BEAT_W-1:0]  win_beats;
    logic               room_now, room_after, last_beat, grant;

    // The current owner is excluded from the overlapped decision.
    always_comb begin
        masked = req_valid;
        if (state_q == ST_ADDR) masked[owner_q] = 1'b0;
    end

    arb_prio_pick #(
        .NUM_REQ  (NUM_REQ),
        .BUS_FIRST(BUS_FIRST)
    ) u_pick (
        .req(masked),
        .any(win_any),
        .idx(win_idx)
    );

    assign win_beats  = req_beats[win_idx*BEAT_W +: BEAT_W];
    assign room_now   = (int'(q_count) < Q_DEPTH);
    assign room_after = ((int'(q_count) + 1 - int'(q_pop)) < Q_DEPTH);
    assign last_beat  = (state_q == ST_ADDR) && ip_addr_ack && (cnt_q == beats_q);

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        beats_d = beats_q;
        cnt_d   = cnt_q;
        grant   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (win_any) begin
                    if (room_now) grant = 1'b1;
                    else          state_d = ST_STALL;
                end
            end
            ST_STALL: begin
                if (!win_any)      state_d = ST_IDLE;
                else if (room_now) grant = 1'b1;
            end
            ST_ADDR: begin
                if (last_beat) begin
                    if (win_any && room_after) grant = 1'b1;
                    else if (win_any)          state_d = ST_STALL;
                    else                       state_d = ST_IDLE;
                end else if (ip_addr_ack) begin
                    cnt_d = cnt_q + BEAT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (grant) begin
            state_d = ST_ADDR;
            owner_d = win_idx;
            beats_d = win_beats;
            cnt_d   = '0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            beats_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            beats_q <= beats_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        addr_active = (state_q == ST_ADDR);
        addr_owner  = owner_q;
        addr_beats  = beats_q;
        push        = last_beat;
    end

endmodule

// File: rtl/arb_order_queue.sv
// In-order queue of completed address phases; the head owns the data phase.
module arb_order_queue #(
    parameter int NUM_REQ = 5,
    parameter int BEAT_W  = 4,
    parameter int Q_DEPTH = 4,
    localparam int IDX_W  = $clog2(NUM_REQ),
    localparam int CNT_W  = $clog2(Q_DEPTH + 1),
    localparam int PTR_W  = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [IDX_W-1:0]  push_owner,
    input  logic [BEAT_W-1:0] push_beats,
    input  logic              ip_data_ack,
    output logic              head_valid,
    output logic [IDX_W-1:0]  head_owner,
    output logic [CNT_W-1:0]  q_count,
    output logic              pop
);

    logic [IDX_W-1:0]  own_mem  [Q_DEPTH];
    logic [BEAT_W-1:0] beat_mem [Q_DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [BEAT_W-1:0] dcnt;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (int'(p) == Q_DEPTH - 1) ? '0 : p + PTR_W'(1);
    endfunction

    assign head_valid = (q_count != '0);
    assign head_owner = own_mem[rd_ptr];
    assign pop        = head_valid && ip_data_ack && (dcnt == beat_mem[rd_ptr]);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            q_count <= '0;
            dcnt    <= '0;
        end else begin
            if (push) begin
                own_mem[wr_ptr]  <= push_owner;
                beat_mem[wr_ptr] <= push_beats;
                wr_ptr           <= ptr_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
                dcnt   <= '0;
            end else if (head_valid && ip_data_ack) begin
                dcnt <= dcnt + BEAT_W'(1);
            end
            q_count <= q_count + CNT_W'(push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/split_phase_arbiter.sv
// Top: address-phase mux, data-phase mux/demux, acknowledge routing.
module split_phase_arbiter #(
    parameter int NUM_CHANNELS = 4,
    parameter int BEAT_W       = 4,
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int Q_DEPTH      = 4,
    parameter bit BUS_FIRST    = 1'b0,
    localparam int NUM_REQ     = NUM_CHANNELS + 1,
    localparam int IDX_W       = $clog2(NUM_REQ),
    localparam int CNT_W       = $clog2(Q_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ-1:0]        req_rnw,
    input  logic [NUM_REQ-1:0]        req_burst,
    input  logic [NUM_REQ*BEAT_W-1:0] req_beats,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input  logic [NUM_REQ*DATA_W-1:0] req_wdata,
    output logic [NUM_REQ-1:0]        req_addr_ack,
    output logic [NUM_REQ-1:0]        req_data_ack,
    output logic [NUM_REQ*DATA_W-1:0] req_rdata,
    output logic                      ip_addr_valid,
    output logic                      ip_rnw,
    output logic                      ip_burst,
    output logic [BEAT_W-1:0]         ip_beats,
    output logic [ADDR_W-1:0]         ip_addr,
    input  logic                      ip_addr_ack,
    output logic [DATA_W-1:0]         ip_wdata,
    input  logic                      ip_data_ack,
    input  logic [DATA_W-1:0]         ip_rdata
);

    logic              addr_active;
    logic [IDX_W-1:0]  addr_owner;
    logic [BEAT_W-1:0] addr_beats;
    logic              fsm_push;
    logic              head_valid;
    logic [IDX_W-1:0]  data_owner;
    logic [CNT_W-1:0]  q_count;
    logic              q_pop;

    arb_addr_fsm #(
        .NUM_REQ  (NUM_REQ),
        .BEAT_W   (BEAT_W),
        .Q_DEPTH  (Q_DEPTH),
        .BUS_FIRST(BUS_FIRST)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_beats  (req_beats),
        .ip_addr_ack(ip_addr_ack),
        .q_count    (q_count),
        .q_pop      (q_pop),
        .addr_active(addr_active),
        .addr_owner (addr_owner),
        .addr_beats (addr_beats),
        .push       (fsm_push)
    );

    arb_order_queue #(
        .NUM_REQ(NUM_REQ),
        .BEAT_W (BEAT_W),
        .Q_DEPTH(Q_DEPTH)
    ) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (fsm_push),
        .push_owner (addr_owner),
        .push_beats (addr_beats),
        .ip_data_ack(ip_data_ack),
        .head_valid (head_valid),
        .head_owner (data_owner),
        .q_count    (q_count),
        .pop        (q_pop)
    );

    // Address-phase multiplexer.
    always_comb begin
        ip_addr_valid = addr_active;
        ip_beats      = addr_beats;
        if (addr_active) begin
            ip_rnw   = req_rnw[addr_owner];
            ip_burst = req_burst[addr_owner];
            ip_addr  = req_addr[addr_owner*ADDR_W +: ADDR_W];
        end else begin
            ip_rnw   = 1'b0;
            ip_burst = 1'b0;
            ip_addr  = '0;
        end
    end

    // Data-phase multiplexer for write data.
    assign ip_wdata = head_valid ? req_wdata[data_owner*DATA_W +: DATA_W] : '0;

    // Per-requester acknowledge and read-data demultiplexing.
    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_route
            logic is_addr_owner, is_data_owner;
            assign is_addr_owner   = addr_active && (addr_owner == IDX_W'(g));
            assign is_data_owner   = head_valid && (data_owner == IDX_W'(g));
            assign req_addr_ack[g] = is_addr_owner && ip_addr_ack;
            assign req_data_ack[g] = is_data_owner && ip_data_ack;
            assign req_rdata[g*DATA_W +: DATA_W] = is_data_owner ? ip_rdata : '0;
        end
    endgenerate

endmodule

// File: rtl/arb_checker.sv
// Property checker attached to the arbiter top.
module arb_checker #(
    parameter int NUM_REQ = 5,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 3,
    parameter int Q_DEPTH = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] req_valid,
    input logic [NUM_REQ-1:0] req_addr_ack,
    input logic [NUM_REQ-1:0] req_data_ack,
    input logic               ip_addr_valid,
    input logic [IDX_W-1:0]   addr_owner,
    input logic [CNT_W-1:0]   q_count,
    input logic               push
);

    logic [NUM_REQ-1:0] others;
    always_comb begin
        others = req_valid;
        others[addr_owner] = 1'b0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!ip_addr_valid && q_count == '0));

    // R7
    addr_ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_addr_ack));

    // R9
    data_ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_data_ack));

    // R5
    no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (ip_addr_valid && !push) |=> (ip_addr_valid && $stable(addr_owner)));

    // R6
    overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (push && (others != '0) && (int'(q_count) < Q_DEPTH - 1)) |=> ip_addr_valid);

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ip_addr_valid && int'(q_count) == Q_DEPTH) |=> !ip_addr_valid);

    // R11
    idle_addr_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !ip_addr_valid |-> (req_addr_ack == '0));

    // R11
    empty_data_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (q_count == '0) |-> (req_data_ack == '0));

endmodule

bind split_phase_arbiter arb_checker #(
    .NUM_REQ(NUM_REQ),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .Q_DEPTH(Q_DEPTH)
) u_arb_checker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_addr_ack (req_addr_ack),
    .req_data_ack (req_data_ack),
    .ip_addr_valid(ip_addr_valid),
    .addr_owner   (addr_owner),
    .q_count      (q_count),
    .push         (fsm_push)
);

// File: tb/tb_split_phase_arbiter.sv
`timescale 1ns/1ps
module tb_split_phase_arbiter;

    localparam int NCH = 3;
    localparam int NR  = NCH + 1;
    localparam int BW  = 4;
    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int QD  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NR-1:0]    rv;
    logic [NR-1:0]    rnw, burst;
    logic [NR*BW-1:0] beats_f;
    logic [NR*AW-1:0] addr_f;
    logic [NR*DW-1:0] wdata_f;
    logic [NR-1:0]    req_addr_ack, req_data_ack;
    logic [NR*DW-1:0] req_rdata;
    logic             ip_addr_valid, ip_rnw, ip_burst;
    logic [BW-1:0]    ip_beats;
    logic [AW-1:0]    ip_addr;
    logic [DW-1:0]    ip_wdata, ip_rdata;
    logic             aack = 1'b1;
    logic             dack = 1'b1;
    logic [DW-1:0]    rcnt = '0;

    logic [BW-1:0] nbeats [NR];
    logic [BW-1:0] left   [NR];
    logic [NR-1:0] go   = '0;
    logic [NR-1:0] seen = '0;

    int checks = 0;
    int fails  = 0;
    int exp_a[$];
    int exp_d[$];
    int a_beat = 0;
    int d_beat = 0;

    initial for (int i = 0; i < NR; i++) nbeats[i] = '0;

    generate
        for (genvar g = 0; g < NR; g++) begin : g_req
            assign rnw[g]                  = g[0];
            assign burst[g]                = (nbeats[g] != '0);
            assign beats_f[g*BW +: BW]     = nbeats[g];
            assign addr_f[g*AW +: AW]      = AW'(8'h10 * (g + 1));
            assign wdata_f[g*DW +: DW]     = DW'(16'hA000 + g);
        end
    endgenerate

    always @(posedge clk) rcnt <= rcnt + 1'b1;
    assign ip_rdata = 16'h5000 ^ rcnt;

    split_phase_arbiter #(
        .NUM_CHANNELS(NCH), .BEAT_W(BW), .ADDR_W(AW), .DATA_W(DW),
        .Q_DEPTH(QD), .BUS_FIRST(1'b0)
    ) dut (
        .clk(clk), .rst(rst),
        .req_valid(rv), .req_rnw(rnw), .req_burst(burst), .req_beats(beats_f),
        .req_addr(addr_f), .req_wdata(wdata_f),
        .req_addr_ack(req_addr_ack), .req_data_ack(req_data_ack), .req_rdata(req_rdata),
        .ip_addr_valid(ip_addr_valid), .ip_rnw(ip_rnw), .ip_burst(ip_burst),
        .ip_beats(ip_beats), .ip_addr(ip_addr), .ip_addr_ack(aack),
        .ip_wdata(ip_wdata), .ip_data_ack(dack), .ip_rdata(ip_rdata)
    );

    // Requester model: raise on a new issue, drop after the last address ack.
    always @(posedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (rst) begin
                rv[i]   <= 1'b0;
                seen[i] <= go[i];
                left[i] <= '0;
            end else if (go[i] != seen[i]) begin
                seen[i] <= go[i];
                rv[i]   <= 1'b1;
                left[i] <= nbeats[i];
            end else if (rv[i] && req_addr_ack[i]) begin
                if (left[i] == '0) rv[i] <= 1'b0;
                left[i] <= left[i] - 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Driver: start a request and push the expected transaction.
    task automatic issue(input int id, input int nb);
        nbeats[id] = BW'(nb - 1);
        go[id]     = ~go[id];
    endtask

    task automatic expect_txn(input int id, input int nb);
        exp_a.push_back(id * 32 + nb);
        exp_d.push_back(id * 32 + nb);
    endtask

    function automatic int idx_of(input logic [NR-1:0] v);
        for (int i = 0; i < NR; i++) if (v[i]) return i;
        return -1;
    endfunction

    // Monitor / scoreboard.
    always @(negedge clk) begin
        if (!rst) begin
            if ($countones(req_addr_ack) > 1) begin
                chk(0, "R7 address ack not one-hot", req_addr_ack, 0);
            end else if (req_addr_ack != '0) begin
                if (exp_a.size() == 0) begin
                    chk(0, "R11 unexpected address ack", req_addr_ack, 0);
                end else begin
                    int id, eid, eb;
                    id  = idx_of(req_addr_ack);
                    eid = exp_a[0] / 32;
                    eb  = exp_a[0] % 32;
                    if (a_beat == 0) chk(id == eid, "R2/R5 address grant order", id, eid);
                    chk(ip_addr == AW'(8'h10 * (eid + 1)), "R7 address mux", ip_addr, 8'h10 * (eid + 1));
                    chk(ip_rnw == eid[0], "R7 rnw mux", ip_rnw, eid[0]);
                    a_beat++;
                    if (a_beat == eb) begin
                        a_beat = 0;
                        void'(exp_a.pop_front());
                    end
                end
            end
            if ($countones(req_data_ack) > 1) begin
                chk(0, "R9 data ack not one-hot", req_data_ack, 0);
            end else if (req_data_ack != '0) begin
                if (exp_d.size() == 0) begin
                    chk(0, "R11 unexpected data ack", req_data_ack, 0);
                end else begin
                    int id, eid, eb;
                    id  = idx_of(req_data_ack);
                    eid = exp_d[0] / 32;
                    eb  = exp_d[0] % 32;
                    chk(id == eid, "R8 data owner order", id, eid);
                    chk(ip_wdata == DW'(16'hA000 + eid), "R9 write data mux", ip_wdata, 16'hA000 + eid);
                    for (int i = 0; i < NR; i++) begin
                        if (i == eid)
                            chk(req_rdata[i*DW +: DW] == ip_rdata, "R9 read data to owner",
                                req_rdata[i*DW +: DW], ip_rdata);
                        else
                            chk(req_rdata[i*DW +: DW] == '0, "R9 read data held zero",
                                req_rdata[i*DW +: DW], 0);
                    end
                    d_beat++;
                    if (d_beat == eb) begin
                        d_beat = 0;
                        void'(exp_d.pop_front());
                    end
                end
            end
        end
    end

    task automatic drain();
        int n = 0;
        while ((exp_a.size() != 0 || exp_d.size() != 0) && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(exp_a.size() == 0 && exp_d.size() == 0, "R8 all transactions completed",
            exp_a.size() + exp_d.size(), 0);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic count_valid_run(output int run);
        run = 0;
        while (!ip_addr_valid) @(negedge clk);
        while (ip_addr_valid) begin
            run++;
            @(negedge clk);
        end
    endtask

    initial begin
        int run;
        // R1 / R11: reset state, acks from the IP held high with nothing active.
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!ip_addr_valid, "R1 idle after reset", ip_addr_valid, 0);
            chk(req_addr_ack == '0 && req_data_ack == '0, "R11 acks ignored when idle",
                {req_addr_ack, req_data_ack}, 0);
        end

        // R2/R3/R4/R6: four simultaneous requests, priority order 0,1,2,bus.
        @(posedge clk); #1;
        issue(2, 3); issue(0, 1); issue(3, 2); issue(1, 2);
        expect_txn(0, 1); expect_txn(1, 2); expect_txn(2, 3); expect_txn(3, 2);
        @(negedge clk);
        chk(!ip_addr_valid, "R3 no grant before request seen", ip_addr_valid, 0);
        @(negedge clk);
        chk(!ip_addr_valid, "R3 grant registered one cycle later", ip_addr_valid, 0);
        @(negedge clk);
        chk(ip_addr_valid, "R3 grant visible next cycle", ip_addr_valid, 1);
        count_valid_run(run);
        chk(run == 8, "R6 back-to-back address phases without gap", run, 8);
        drain();

        // R5: higher priority arrives during a 4-beat burst of channel 2.
        issue(2, 4); expect_txn(2, 4);
        while (!req_addr_ack[2]) @(negedge clk);
        @(posedge clk); #1;
        issue(0, 1); expect_txn(0, 1);
        drain();

        // R10: data acks held off, queue of depth 2 fills, third request waits.
        dack = 1'b0;
        issue(0, 1); issue(1, 1); issue(2, 1);
        expect_txn(0, 1); expect_txn(1, 1); expect_txn(2, 1);
        repeat (8) @(negedge clk);
        chk(!ip_addr_valid, "R10 no grant while queue full", ip_addr_valid, 0);
        chk(rv[2], "R10 third request still waiting", rv[2], 1);
        chk(req_data_ack == '0, "R10 no data ack while data acks held", req_data_ack, 0);
        @(posedge clk); #1 dack = 1'b1;
        drain();

        // R4: 16-beat address phase of the bus port.
        issue(3, 16); expect_txn(3, 16);
        count_valid_run(run);
        chk(run == 16, "R4 sixteen-beat address phase", run, 16);
        drain();

        // R2: bus port loses to a channel when both request together.
        issue(3, 1); issue(2, 2);
        expect_txn(2, 2); expect_txn(3, 1);
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual=%0d expected=%0d", 20000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule